// File: doc/BRIEF.md
# Programmable-Length SPI Master with Register Interface

This block is an SPI master that sits on a simple 32-bit register bus. Software loads up to four 32-bit data words, picks a clock divider and a set of peripheral select lines, and then writes the control word with the start bit set. The controller shifts out a character of 1 to 128 bits on MOSI. It samples the same number of bits from MISO and writes them back into the data words in place of the transmitted bits. Software learns that the transfer is done by polling the busy flag or by taking the interrupt.

The launch edge for MOSI and the capture edge for MISO are chosen independently, and either bit order can be used. The select lines can follow the select register directly, or they can be gated so that they are active only while a transfer runs. A bus read returns its data on `bus_rdata` one clock after `bus_rd` is sampled high.

Top module: `spi_master_regs`

## Requirements
- R1: After reset all registers and data words read as zero, SCLK is low, every select line is high and the interrupt is low.
- R2: Word addresses 0 to 3 are the data words, address 4 is control, address 5 is the divider and address 6 is the select register. Written values read back one cycle after a read strobe, and address 7 reads zero.
- R3: Writing control with bit 8 set starts a transfer. Bit 8 reads 1 until the last SCLK falling edge of the transfer and 0 after it.
- R4: Control bits 7:0 give the number of bits per transfer, and the value 0 selects 128. Bit position p of the character is bit p%32 of data word p/32.
- R5: With control bit 11 set, character bit 0 is sent first; with it clear, the highest character bit is sent first. Received bits land in the same order.
- R6: With control bit 10 set, MOSI takes the first bit before the first SCLK edge and changes on falling edges. With it clear, MOSI changes on rising edges.
- R7: With control bit 9 set, MISO is captured on falling SCLK edges; with it clear, on rising edges.
- R8: SCLK idles low, toggles only during a transfer, and has a period of 2*(divider+1) clock cycles.
- R9: Received bits replace the transmitted bits at character positions below the length. All higher data bits keep their values.
- R10: A line `ss_n[i]` is low when select bit i is 1. When control bit 13 is set, it is low only while a transfer is busy.
- R11: With control bit 12 set, `irq` rises when a transfer completes. Any read or write of the control register clears it. With bit 12 clear it stays low.
- R12: While a transfer is busy, writes to the data, control and divider registers have no effect, and writes to the select register take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| ss_n | output | 4 | Active-low peripheral selects |
| miso | input | 1 | Serial data from the peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
If the bit index or the edge choice is wrong, the peripheral sees a scrambled character on MOSI within the first few SCLK edges. The data words are also corrupted, and this shows in the readback right after completion. If the fall counter or the busy flag is wrong, the transfer either ends early, leaving stale data bits, or never ends, so the busy poll times out. If the divider or the clock enable is wrong, the spacing between the first two rising SCLK edges changes, and that spacing is measured on every transfer. Faults in the select and interrupt gating appear on `ss_n` and `irq` in the cycle after the busy flag changes.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int LEN_W  = 8;
  localparam int GO_BIT = 8;

  typedef struct packed {
    logic             auto_ss;
    logic             irq_en;
    logic             lsb_first;
    logic             tx_fall;
    logic             rx_fall;
    logic             go;
    logic [LEN_W-1:0] len;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && (cnt == div);
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core import spi_pkg::*; #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(NWORDS),
  localparam int DATA_BITS = NWORDS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 start,
  input  logic                 lsb_first,
  input  logic                 tx_fall,
  input  logic                 rx_fall,
  input  logic [LEN_W-1:0]     nbits,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 miso,
  output logic                 mosi,
  output logic [DATA_BITS-1:0] store
);
  localparam int IDX_W = $clog2(DATA_BITS);

  logic [LEN_W-1:0] tx_k, rx_k;
  logic [IDX_W-1:0] tx_idx, rx_idx, first_idx;
  logic             tx_step, rx_step;

  // character position of the k-th serial bit
  function automatic logic [IDX_W-1:0] bit_pos(input logic [LEN_W-1:0] k,
                                               input logic lsb,
                                               input logic [LEN_W-1:0] n);
    return lsb ? IDX_W'(k) : IDX_W'(n - 1'b1 - k);
  endfunction

  assign tx_idx    = bit_pos(tx_k, lsb_first, nbits);
  assign rx_idx    = bit_pos(rx_k, lsb_first, nbits);
  assign first_idx = bit_pos('0, lsb_first, nbits);
  assign tx_step   = (rise && !tx_fall) || (fall && tx_fall && (tx_k < nbits));
  assign rx_step   = (rise && !rx_fall) || (fall && rx_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= '0;
      tx_k  <= '0;
      rx_k  <= '0;
      mosi  <= 1'b0;
    end else begin
      if (wr_en)
        store[wr_sel*WORD_W +: WORD_W] <= wr_data;
      if (start) begin
        rx_k <= '0;
        if (tx_fall) begin
          mosi <= store[first_idx];
          tx_k <= LEN_W'(1);
        end else begin
          tx_k <= '0;
        end
      end else begin
        if (tx_step) begin
          mosi <= store[tx_idx];
          tx_k <= tx_k + 1'b1;
        end
        if (rx_step) begin
          store[rx_idx] <= miso;
          rx_k <= rx_k + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs import spi_pkg::*; #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32,
  parameter int NSEL   = 4,
  parameter int DIV_W  = 16,
  localparam int ADDR_W = $clog2(NWORDS + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  output logic [NSEL-1:0]   ss_n,
  input  logic              miso,
  output logic              irq
);
  localparam int SEL_W     = $clog2(NWORDS);
  localparam int DATA_BITS = NWORDS * WORD_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NWORDS);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(NWORDS + 1);
  localparam logic [ADDR_W-1:0] A_SS   = ADDR_W'(NWORDS + 2);
  localparam logic [LEN_W-1:0]  MAXLEN = LEN_W'(DATA_BITS);

  ctrl_t                ctrl_q, cfg_wr;
  logic                 busy_q, start, ctrl_hit, data_wr;
  logic                 rise_ev, fall_ev, last_fall;
  logic [DIV_W-1:0]     div_q;
  logic [NSEL-1:0]      ss_q;
  logic [LEN_W-1:0]     fall_cnt, nbits, now_len;
  logic                 now_lsb, now_txf, now_rxf;
  logic [DATA_BITS-1:0] store;
  logic [WORD_W-1:0]    rd_word;

  assign cfg_wr   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign ctrl_hit = (bus_wr || bus_rd) && (bus_addr == A_CTRL);
  assign start    = bus_wr && (bus_addr == A_CTRL) && !busy_q && bus_wdata[GO_BIT];
  assign data_wr  = bus_wr && !busy_q && (bus_addr < A_CTRL);

  // the starting write supplies the configuration in its own cycle
  assign now_len = start ? cfg_wr.len       : ctrl_q.len;
  assign now_lsb = start ? cfg_wr.lsb_first : ctrl_q.lsb_first;
  assign now_txf = start ? cfg_wr.tx_fall   : ctrl_q.tx_fall;
  assign now_rxf = start ? cfg_wr.rx_fall   : ctrl_q.rx_fall;
  assign nbits   = (now_len == '0 || now_len > MAXLEN) ? MAXLEN : now_len;

  assign last_fall = fall_ev && (fall_cnt == nbits - 1'b1);
  assign ss_n      = ~(ss_q & {NSEL{!ctrl_q.auto_ss || busy_q}});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      ctrl_q   <= '0;
      div_q    <= '0;
      ss_q     <= '0;
      fall_cnt <= '0;
      irq      <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_SS)
        ss_q <= bus_wdata[NSEL-1:0];
      if (bus_wr && !busy_q && bus_addr == A_CTRL) begin
        ctrl_q    <= cfg_wr;
        ctrl_q.go <= 1'b0;
      end
      if (bus_wr && !busy_q && bus_addr == A_DIV)
        div_q <= bus_wdata[DIV_W-1:0];
      if (start) begin
        busy_q   <= 1'b1;
        fall_cnt <= '0;
      end else if (busy_q && fall_ev) begin
        if (last_fall) busy_q <= 1'b0;
        else           fall_cnt <= fall_cnt + 1'b1;
      end
      if (busy_q && last_fall && ctrl_q.irq_en) irq <= 1'b1;
      else if (ctrl_hit)                        irq <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr < A_CTRL) begin
      rd_word = store[bus_addr[SEL_W-1:0]*WORD_W +: WORD_W];
    end else if (bus_addr == A_CTRL) begin
      rd_word[CTRL_W-1:0] = ctrl_q;
      rd_word[GO_BIT]     = busy_q;
    end else if (bus_addr == A_DIV) begin
      rd_word[DIV_W-1:0] = div_q;
    end else if (bus_addr == A_SS) begin
      rd_word[NSEL-1:0] = ss_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  spi_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .div  (div_q),
    .sclk (sclk),
    .rise (rise_ev),
    .fall (fall_ev)
  );

  spi_shift_core #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (data_wr),
    .wr_sel    (bus_addr[SEL_W-1:0]),
    .wr_data   (bus_wdata),
    .start     (start),
    .lsb_first (now_lsb),
    .tx_fall   (now_txf),
    .rx_fall   (now_rxf),
    .nbits     (nbits),
    .rise      (rise_ev),
    .fall      (fall_ev),
    .miso      (miso),
    .mosi      (mosi),
    .store     (store)
  );
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk #(
  parameter int NWORDS = 4,
  parameter int NSEL   = 4,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              sclk,
  input logic              fall_ev,
  input logic              irq,
  input logic              irq_en,
  input logic              auto_ss,
  input logic [NSEL-1:0]   ss_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DIV_W-1:0]  div_q
);
  localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(NWORDS + 1);

  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);

  // R8
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(busy));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(fall_ev));

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($fell(busy) && irq_en));

  // R10
  ss_auto_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_ss && !busy) |-> (&ss_n));

  // R12
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == DIV_ADDR) |=> $stable(div_q));
endmodule

bind spi_master_regs spi_master_regs_chk #(
  .NWORDS (NWORDS),
  .NSEL   (NSEL),
  .DIV_W  (DIV_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy_q),
  .sclk     (sclk),
  .fall_ev  (fall_ev),
  .irq      (irq),
  .irq_en   (ctrl_q.irq_en),
  .auto_ss  (ctrl_q.auto_ss),
  .ss_n     (ss_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .div_q    (div_q)
);

// File: tb/tb_spi_master_regs.sv
`timescale 1ns/1ps
module tb_spi_master_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso, irq;
  logic [3:0]  ss_n;

  int checks = 0;
  int errors = 0;

  // slave model state
  logic [127:0] s_seq, s_cap;
  int  s_ri, s_ci, s_rc;
  bit  s_txf = 1'b0, s_rxf = 1'b0;
  longint t_r0, t_r1;

  always #2 clk = ~clk;

  spi_master_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .ss_n(ss_n), .miso(miso), .irq(irq)
  );

  always @(posedge sclk) begin
    if (s_rc == 0) t_r0 = $time;
    if (s_rc == 1) t_r1 = $time;
    s_rc++;
    if (s_txf) begin
      if (s_ci < 128) s_cap[s_ci] = mosi;
      s_ci++;
    end
    if (!s_rxf) begin
      s_ri++;
      if (s_ri < 128) miso = s_seq[s_ri];
    end
  end

  always @(negedge sclk) begin
    if (!s_txf) begin
      if (s_ci < 128) s_cap[s_ci] = mosi;
      s_ci++;
    end
    if (s_rxf) begin
      s_ri++;
      if (s_ri < 128) miso = s_seq[s_ri];
    end
  end

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // tasks are entered at a falling clock edge and return at one
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] r;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      bus_read(3'd4, r);
      if (!r[8]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [127:0] exp_mosi(input logic [127:0] tx, input int n, input bit lsb);
    logic [127:0] v = '0;
    for (int j = 0; j < n; j++) v[j] = lsb ? tx[j] : tx[n-1-j];
    return v;
  endfunction

  function automatic logic [127:0] exp_store(input logic [127:0] tx, input logic [127:0] rx,
                                             input int n, input bit lsb);
    logic [127:0] v = tx;
    for (int j = 0; j < n; j++) v[lsb ? j : n-1-j] = rx[j];
    return v;
  endfunction

  task automatic run_xfer(input logic [127:0] tx, input logic [7:0] len, input bit lsb,
                          input bit txf, input bit rxf, input bit ie, input int div,
                          input logic [127:0] rxs);
    int n;
    bit ok;
    logic [31:0] r;
    logic [127:0] got, mask;
    n = (len == 0) ? 128 : int'(len);
    for (int w = 0; w < 4; w++) bus_write(3'(w), tx[w*32 +: 32]);
    bus_write(3'd5, 32'(div));
    s_seq = rxs; s_ri = 0; s_ci = 0; s_rc = 0; s_cap = '0;
    s_txf = txf; s_rxf = rxf; miso = rxs[0];
    bus_write(3'd4, {18'b0, 1'b0, ie, lsb, txf, rxf, 1'b1, len});
    bus_read(3'd4, r);
    check("R3", "busy after start", 128'(r[8]), 128'(1));
    if (ie) begin
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
        if (irq) begin ok = 1'b1; break; end
        @(negedge clk);
      end
      check("R11", "irq raised on completion", 128'(ok), 128'(1));
      bus_read(3'd4, r);
      check("R3", "busy clear at irq", 128'(r[8]), 128'(0));
      check("R11", "irq cleared by control read", 128'(irq), 128'(0));
    end else begin
      wait_idle(ok);
      check("R3", "busy clears", 128'(ok), 128'(1));
      check("R11", "irq stays low when disabled", 128'(irq), 128'(0));
    end
    mask = (n == 128) ? '1 : ((128'(1) << n) - 1);
    check("R5/R6", "mosi bit count", 128'(s_ci), 128'(n));
    check("R5/R6", "mosi sequence", s_cap & mask, exp_mosi(tx, n, lsb));
    for (int w = 0; w < 4; w++) begin
      bus_read(3'(w), r);
      got[w*32 +: 32] = r;
    end
    check("R4/R7/R9", "data words after transfer", got, exp_store(tx, rxs, n, lsb));
    if (n >= 2)
      check("R8", "sclk period ns", 128'(t_r1 - t_r0), 128'(2 * (div + 1) * 4));
    check("R8", "sclk idle low", 128'(sclk), 128'(0));
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [127:0] tx, rx;
    int unsigned seed;
    bit ok;
    seed = $urandom(32'd20240611);
    miso = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", "sclk", 128'(sclk), 128'(0));
    check("R1", "ss_n", 128'(ss_n), 128'hF);
    check("R1", "irq", 128'(irq), 128'(0));
    bus_read(3'd4, r); check("R1", "control", 128'(r), 128'(0));
    bus_read(3'd5, r); check("R1", "divider", 128'(r), 128'(0));
    bus_read(3'd0, r); check("R1", "word 0", 128'(r), 128'(0));

    // R2 register map
    bus_write(3'd5, 32'h0000_1234);
    bus_read(3'd5, r); check("R2", "divider readback", 128'(r), 128'h1234);
    bus_write(3'd6, 32'h0000_000A);
    bus_read(3'd6, r); check("R2", "select readback", 128'(r), 128'hA);
    bus_write(3'd4, 32'h0000_3E21);
    bus_read(3'd4, r); check("R2", "control readback", 128'(r), 128'h3E21);
    bus_write(3'd2, 32'hCAFE_0042);
    bus_read(3'd2, r); check("R2", "word 2 readback", 128'(r), 128'hCAFE_0042);
    bus_read(3'd7, r); check("R2", "unused address", 128'(r), 128'(0));
    bus_write(3'd4, 32'h0);
    check("R10", "select without auto", 128'(ss_n), 128'h5);

    // directed transfers: edge combinations, bit orders, lengths
    run_xfer({4{32'hA5C3_0F96}}, 8'd1,   1'b0, 1'b0, 1'b0, 1'b0, 0, {4{32'h5555_AAAA}});
    run_xfer({4{32'h1357_9BDF}}, 8'd8,   1'b1, 1'b1, 1'b0, 1'b0, 1, {4{32'h0F0F_3C3C}});
    run_xfer({4{32'hDEAD_BEEF}}, 8'd33,  1'b0, 1'b0, 1'b1, 1'b1, 2, {4{32'h8421_1248}});
    run_xfer({4{32'h0123_4567}}, 8'd0,   1'b1, 1'b1, 1'b1, 1'b0, 0, {4{32'hFEDC_BA98}});
    run_xfer({4{32'h7E81_3CC3}}, 8'd128, 1'b0, 1'b1, 1'b1, 1'b1, 1, {4{32'h6969_9696}});

    // R10 automatic select, R12 writes during busy
    bus_write(3'd0, 32'h0000_00C3);
    bus_write(3'd3, 32'h1111_2222);
    bus_write(3'd5, 32'd3);
    bus_write(3'd6, 32'h5);
    bus_write(3'd4, 32'h0000_2000);
    check("R10", "auto select idle high", 128'(ss_n), 128'hF);
    s_seq = '0; s_ri = 0; s_ci = 0; s_rc = 0; s_txf = 1'b0; s_rxf = 1'b0; miso = 1'b0;
    bus_write(3'd4, 32'h0000_2110);
    check("R10", "auto select low while busy", 128'(ss_n), 128'hA);
    bus_write(3'd6, 32'h3);
    check("R12", "select write while busy", 128'(ss_n), 128'hC);
    bus_write(3'd5, 32'd7);
    bus_write(3'd3, 32'h9999_8888);
    bus_write(3'd4, 32'h0000_0005);
    wait_idle(ok);
    check("R3", "busy clears", 128'(ok), 128'(1));
    check("R10", "auto select high after done", 128'(ss_n), 128'hF);
    bus_read(3'd5, r); check("R12", "divider kept", 128'(r), 128'(3));
    bus_read(3'd3, r); check("R12", "word 3 kept", 128'(r), 128'h1111_2222);
    bus_read(3'd4, r); check("R12", "control kept", 128'(r), 128'h2010);
    bus_read(3'd0, r); check("R9", "16 zeros received", 128'(r), 128'(0));
    bus_write(3'd4, 32'h0);
    bus_write(3'd6, 32'h0);

    // random transfers
    for (int k = 0; k < 24; k++) begin
      tx = {$urandom(), $urandom(), $urandom(), $urandom()};
      rx = {$urandom(), $urandom(), $urandom(), $urandom()};
      run_xfer(tx, 8'($urandom_range(0, 128)), 1'($urandom()), 1'($urandom()),
               1'($urandom()), 1'($urandom()), int'($urandom_range(0, 3)), rx);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule